// File: doc/BRIEF.md
# Chip-Select Output Bank

This block drives a bank of general-purpose output pins. Each pin can act as a chip select for a serial peripheral. It holds two words.

The configuration word sets two things for each pin. One field marks whether the pin is used as a chip select; that field is reported outward for the pin routing to use. The other field inverts the pin's physical level, so an active-high device can be served with the same latch convention as an active-low one.

A write-only command word carries one set field and one clear field. Software can change any group of output latches in a single write, with no read-modify-write. The latches and the configuration word can be read back. The physical levels come out of a register stage.

Top module: `cs_out_bank`

## Requirements
- R1: After reset every output latch is 1, the configuration word is 0, and every physical output is 1.
- R2: A configuration write stores the whole word and makes it readable on `cfg_o` from the next cycle. Bits [15:8] of the word are the per-pin chip-select marks, shown on `cs_sel_o`. Bits [7:0] are the per-pin inversion bits.
- R3: In a command write, bit 8+i being 1 with bit i being 0 sets latch i to 1.
- R4: In a command write, bit i being 1 with bit 8+i being 0 clears latch i to 0.
- R5: A latch whose set bit and clear bit are both 0 keeps its value. A latch whose set bit and clear bit are both 1 also keeps its value.
- R6: Physical output i equals latch i XOR inversion bit i, taken one clock after the latch and configuration values it follows.
- R7: Writing 0 to the configuration word makes every physical output equal its latch again.
- R8: Command data is ignored while `cmd_we` is low. A configuration write and a command write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration data: [15:8] chip-select marks, [7:0] inversion bits |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command data: [15:8] set, [7:0] clear |
| cfg_o | output | 16 | Readback of the configuration word |
| cs_sel_o | output | 8 | Per-pin chip-select marks |
| latch_o | output | 8 | Readable latch status |
| pin_o | output | 8 | Registered physical output levels |

## Verification
The checker holds several rules on every cycle:
- A command's set-only and clear-only bits land in the latches.
- With no command, the latches stay put.
- A configuration write is stored.
- Each pin equals the previous cycle's latch XOR the previous cycle's inversion bits.

Some cases can only be shown by the bench's scenarios. These are the both-bits-set hold, the exact reset values, and the one-cycle lag of a pin behind its latch. The bench also shows simultaneous configuration and command writes, and the return to plain outputs after a zero configuration.

// File: rtl/cs_out_bank.sv
module cs_out_bank #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2*PINS-1:0] cfg_wdata,
  input  logic              cmd_we,
  input  logic [2*PINS-1:0] cmd_wdata,
  output logic [2*PINS-1:0] cfg_o,
  output logic [PINS-1:0]   cs_sel_o,
  output logic [PINS-1:0]   latch_o,
  output logic [PINS-1:0]   pin_o
);
  logic [2*PINS-1:0] cfg_q;
  logic [PINS-1:0]   latch_q, pin_q, set_only, clr_only;

  assign set_only = cmd_wdata[2*PINS-1:PINS] & ~cmd_wdata[PINS-1:0];
  assign clr_only = cmd_wdata[PINS-1:0] & ~cmd_wdata[2*PINS-1:PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      latch_q <= '1;
      pin_q   <= '1;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (cmd_we) latch_q <= (latch_q | set_only) & ~clr_only;
      pin_q <= latch_q ^ cfg_q[PINS-1:0];
    end
  end

  assign cfg_o    = cfg_q;
  assign cs_sel_o = cfg_q[2*PINS-1:PINS];
  assign latch_o  = latch_q;
  assign pin_o    = pin_q;
endmodule

// File: rtl/cs_out_bank_chk.sv
module cs_out_bank_chk #(
  parameter int PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2*PINS-1:0] cfg_wdata,
  input logic              cmd_we,
  input logic [2*PINS-1:0] cmd_wdata,
  input logic [2*PINS-1:0] cfg_o,
  input logic [PINS-1:0]   latch_o,
  input logic [PINS-1:0]   pin_o
);
  p_cfg_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_o == $past(cfg_wdata));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> ((latch_o & $past(cmd_wdata[2*PINS-1:PINS] & ~cmd_wdata[PINS-1:0]))
                == $past(cmd_wdata[2*PINS-1:PINS] & ~cmd_wdata[PINS-1:0])));

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> ((latch_o & $past(cmd_wdata[PINS-1:0] & ~cmd_wdata[2*PINS-1:PINS])) == '0));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(latch_o));

  p_pin_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pin_o == $past(latch_o ^ cfg_o[PINS-1:0]));
endmodule

bind cs_out_bank cs_out_bank_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cfg_o(cfg_o),
  .latch_o(latch_o), .pin_o(pin_o)
);

// File: tb/cs_out_bank_test.sv
module cs_out_bank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cmd_we = 1'b0;
  logic [15:0] cfg_wdata = '0, cmd_wdata = '0;
  logic [15:0] cfg_o;
  logic [7:0]  cs_sel_o, latch_o, pin_o;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  cs_out_bank uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cfg_o(cfg_o),
    .cs_sel_o(cs_sel_o), .latch_o(latch_o), .pin_o(pin_o)
  );

  // {cfg_en, cfg, cmd_en, cmd, exp_latch, exp_pin}
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b1, 16'h0001, 8'hFE, 8'hFE},  // R4
    {1'b0, 16'h0000, 1'b1, 16'h00F0, 8'h0E, 8'h0E},  // R4
    {1'b0, 16'h0000, 1'b1, 16'h0300, 8'h0F, 8'h0F},  // R3
    {1'b0, 16'h0000, 1'b1, 16'h0101, 8'h0F, 8'h0F},  // R5 both set
    {1'b0, 16'h0000, 1'b1, 16'h0000, 8'h0F, 8'h0F},  // R5 both clear
    {1'b1, 16'h0102, 1'b0, 16'h0000, 8'h0F, 8'h0D},  // R6 invert pin1
    {1'b0, 16'h0000, 1'b0, 16'h00FF, 8'h0F, 8'h0D},  // R8 ignored
    {1'b1, 16'hFFFF, 1'b1, 16'hF00F, 8'hF0, 8'h0F},  // R8 simultaneous
    {1'b1, 16'h0000, 1'b0, 16'h0000, 8'hF0, 8'hF0},  // R7
    {1'b0, 16'h0000, 1'b1, 16'hFF00, 8'hFF, 8'hFF}   // R3 all high
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ce, input logic [15:0] c, input logic me, input logic [15:0] m);
    @(negedge clk);
    cfg_we = ce; cfg_wdata = c; cmd_we = me; cmd_wdata = m;
    @(negedge clk);
    cfg_we = 1'b0; cmd_we = 1'b0; cmd_wdata = 16'h00FF;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 latch", {8'h0, latch_o}, 16'h00FF);
    chk("R1 cfg", cfg_o, 16'h0000);
    chk("R1 pin", {8'h0, pin_o}, 16'h00FF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      wr(v[49], v[48:33], v[32], v[31:16]);
      chk($sformatf("R3 table latch %0d", i), {8'h0, latch_o}, {8'h0, v[15:8]});
      @(negedge clk);
      chk($sformatf("R6 table pin %0d", i), {8'h0, pin_o}, {8'h0, v[7:0]});
    end

    wr(1'b1, 16'hA55A, 1'b0, 16'h0000);
    chk("R2 cfg readback", cfg_o, 16'hA55A);
    chk("R2 cs marks", {8'h0, cs_sel_o}, 16'h00A5);
    wr(1'b1, 16'h0000, 1'b0, 16'h0000);
    @(negedge clk);

    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = 16'h00FF;
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R6 lag latch", {8'h0, latch_o}, 16'h0000);
    chk("R6 lag pin old", {8'h0, pin_o}, 16'h00FF);
    @(negedge clk);
    chk("R6 lag pin new", {8'h0, pin_o}, 16'h0000);

    wr(1'b1, 16'h0081, 1'b0, 16'h0000);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rerst latch", {8'h0, latch_o}, 16'h00FF);
    chk("R1 rerst cfg", cfg_o, 16'h0000);
    chk("R1 rerst pin", {8'h0, pin_o}, 16'h00FF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule